// File: doc/BRIEF.md
# Per-Core Interrupt Acceptance and End-of-Interrupt Unit

This block sits beside a processor core and decides which incoming interrupt the core takes next. It keeps three 256-bit arrays indexed by vector number: a pending-request array, an in-service array and a trigger-kind array. Interrupt messages arrive with a vector number and a flag saying whether the source is level- or edge-triggered. The core sees a single request line together with the vector that would be delivered. It acknowledges to take that vector. When its handler finishes, software writes an end-of-interrupt strobe.

Arbitration works on priority classes, where a vector's class is its upper four bits. The best pending vector is presented only if its class is strictly above the class held in a software-written task priority register and strictly above the class of the highest vector already in service. Nested delivery is therefore possible only for a higher class. A repeat of a vector that is still in service waits as one pending request. Extra repeats beyond that one are lost.

An end-of-interrupt retires the highest in-service vector. If that vector was accepted as level-triggered, the unit sends a one-cycle broadcast carrying the vector so that downstream I/O interrupt controllers can re-arm the line. A global enable gates the whole unit.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset the request, in-service and trigger-kind arrays are all zero, the task priority is 0, `irq_out` is low and `eoi_bcast_valid` is low.
- R2: A message (`msg_valid` high while `sw_enable` is high) whose request bit is clear sets that request bit and records the trigger kind (1 = level, 0 = edge). The updated state is visible from the next clock edge.
- R3: `irq_out` is high exactly when the highest pending vector's class (`vector[7:4]`) is greater than `tpr[7:4]` and, if anything is in service, greater than the class of the highest in-service vector. `ack_vector` then shows that highest pending vector. With a task priority of zero, every vector of class 1 or above can be presented.
- R4: `ack` while `irq_out` is high clears the presented vector's request bit and sets its in-service bit in one cycle, and `ack_vector` gives the vector during that cycle. `ack` while `irq_out` is low has no effect.
- R5: `eoi_wr` clears the highest-numbered in-service bit. In the following cycle, `eoi_bcast_valid` pulses high for one cycle with `eoi_bcast_vector` equal to the retired vector, but only if its trigger kind is level. An edge vector produces no pulse.
- R6: `eoi_wr` with nothing in service changes no state and produces no broadcast.
- R7: A message for a vector that is in service but not pending becomes pending. It is presented only after the EOI for the first instance.
- R8: A message for a vector whose request bit is already set is absorbed: the vector is delivered once and its recorded trigger kind is unchanged.
- R9: While `sw_enable` is low, `irq_out` is low and incoming messages are dropped for good. Requests accepted before the enable was cleared are presented again once it is set.
- R10: `tpr_wr` loads `tpr_data` into the task priority at the clock edge, and the new value governs `irq_out` from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_enable | input | 1 | Global unit enable |
| msg_valid | input | 1 | Incoming interrupt message strobe |
| msg_vector | input | 8 | Vector of incoming message |
| msg_level | input | 1 | Trigger kind of message, 1 = level |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_data | input | 8 | Task priority write value |
| ack | input | 1 | Core acknowledge |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| irq_out | output | 1 | Interrupt request to core |
| ack_vector | output | 8 | Vector presented / taken on acknowledge |
| eoi_bcast_valid | output | 1 | One-cycle EOI broadcast strobe |
| eoi_bcast_vector | output | 8 | Vector carried by EOI broadcast |

## Verification
The bound checker watches every cycle for the following. A broadcast must never appear without an end-of-interrupt write in the cycle before it. An EOI against an empty in-service array must stay silent. A taken acknowledge must grow the in-service population by exactly one, and the vector just taken must not be offered again at once. While the unit is disabled, the request array must stay frozen. A repeat arriving on a pending vector must leave the trigger-kind array unchanged. Some behaviours need an ordered history and are shown only by the bench's scenarios: class-based nesting and masking, which in-service vector an EOI retires, back-to-back delivery of a repeat after EOI, loss of a third repeat, and the effect of task-priority writes.

// File: rtl/irq_accept_unit.sv
module irq_accept_unit #(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_enable,
  input  logic             msg_valid,
  input  logic [VEC_W-1:0] msg_vector,
  input  logic             msg_level,
  input  logic             tpr_wr,
  input  logic [VEC_W-1:0] tpr_data,
  input  logic             ack,
  input  logic             eoi_wr,
  output logic             irq_out,
  output logic [VEC_W-1:0] ack_vector,
  output logic             eoi_bcast_valid,
  output logic [VEC_W-1:0] eoi_bcast_vector
);
  localparam int NVEC = 1 << VEC_W;
  localparam int CLS_LO = VEC_W - CLS_W;

  logic [NVEC-1:0]  irr_q, isr_q, tmr_q;
  logic [NVEC-1:0]  irr_d, isr_d, tmr_d;
  logic [VEC_W-1:0] tpr_q;
  logic [VEC_W-1:0] hp_vec, is_vec;
  logic             hp_any, is_any, take, retire, accept;

  function automatic logic [VEC_W-1:0] top_idx(input logic [NVEC-1:0] v);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = 0; i < NVEC; i++)
      if (v[i]) r = i[VEC_W-1:0];
    return r;
  endfunction

  assign hp_any = |irr_q;
  assign is_any = |isr_q;
  assign hp_vec = top_idx(irr_q);
  assign is_vec = top_idx(isr_q);

  assign irq_out = sw_enable && hp_any
                && (hp_vec[VEC_W-1:CLS_LO] > tpr_q[VEC_W-1:CLS_LO])
                && (!is_any || hp_vec[VEC_W-1:CLS_LO] > is_vec[VEC_W-1:CLS_LO]);
  assign ack_vector = hp_vec;

  assign take   = ack && irq_out;
  assign retire = eoi_wr && is_any;
  assign accept = sw_enable && msg_valid && !irr_q[msg_vector];

  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (retire) isr_d[is_vec] = 1'b0;
    if (take) begin
      irr_d[hp_vec] = 1'b0;
      isr_d[hp_vec] = 1'b1;
    end
    if (accept) begin
      irr_d[msg_vector] = 1'b1;
      tmr_d[msg_vector] = msg_level;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q            <= '0;
      isr_q            <= '0;
      tmr_q            <= '0;
      tpr_q            <= '0;
      eoi_bcast_valid  <= 1'b0;
      eoi_bcast_vector <= '0;
    end else begin
      irr_q           <= irr_d;
      isr_q           <= isr_d;
      tmr_q           <= tmr_d;
      eoi_bcast_valid <= retire && tmr_q[is_vec];
      if (retire) eoi_bcast_vector <= is_vec;
      if (tpr_wr) tpr_q <= tpr_data;
    end
  end
endmodule

// File: rtl/irq_accept_unit_chk.sv
module irq_accept_unit_chk #(
  parameter int VEC_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sw_enable,
  input logic                    msg_valid,
  input logic [VEC_W-1:0]        msg_vector,
  input logic                    ack,
  input logic                    eoi_wr,
  input logic                    irq_out,
  input logic [VEC_W-1:0]        ack_vector,
  input logic                    eoi_bcast_valid,
  input logic [(1<<VEC_W)-1:0]   irr_q,
  input logic [(1<<VEC_W)-1:0]   isr_q,
  input logic [(1<<VEC_W)-1:0]   tmr_q
);
  assert_bcast_needs_eoi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast_valid |-> $past(eoi_wr));

  assert_empty_eoi_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && isr_q == '0) |=> !eoi_bcast_valid);

  assert_ack_grows_isr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out && !eoi_wr) |=> $countones(isr_q) == $countones($past(isr_q)) + 1);

  assert_taken_not_reoffered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out) |=> !(irq_out && ack_vector == $past(ack_vector)));

  assert_disabled_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_enable |=> $stable(irr_q));

  assert_absorb_keeps_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && irr_q[msg_vector]) |=> $stable(tmr_q));
endmodule

bind irq_accept_unit irq_accept_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .msg_valid(msg_valid),
  .msg_vector(msg_vector), .ack(ack), .eoi_wr(eoi_wr), .irq_out(irq_out),
  .ack_vector(ack_vector), .eoi_bcast_valid(eoi_bcast_valid),
  .irr_q(irr_q), .isr_q(isr_q), .tmr_q(tmr_q)
);

// File: tb/irq_accept_unit_tb.sv
module irq_accept_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_enable = 1'b1;
  logic       msg_valid = 1'b0;
  logic [7:0] msg_vector = '0;
  logic       msg_level = 1'b0;
  logic       tpr_wr = 1'b0;
  logic [7:0] tpr_data = '0;
  logic       ack = 1'b0;
  logic       eoi_wr = 1'b0;
  logic       irq_out;
  logic [7:0] ack_vector;
  logic       eoi_bcast_valid;
  logic [7:0] eoi_bcast_vector;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_accept_unit u_dut (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .msg_valid(msg_valid),
    .msg_vector(msg_vector), .msg_level(msg_level), .tpr_wr(tpr_wr),
    .tpr_data(tpr_data), .ack(ack), .eoi_wr(eoi_wr), .irq_out(irq_out),
    .ack_vector(ack_vector), .eoi_bcast_valid(eoi_bcast_valid),
    .eoi_bcast_vector(eoi_bcast_vector)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] v, input logic lvl);
    @(negedge clk);
    msg_valid = 1'b1; msg_vector = v; msg_level = lvl;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic take(input string req, input logic [7:0] exp);
    @(negedge clk);
    check({req, " irq before ack"}, irq_out, 1);
    check({req, " ack vector"}, ack_vector, exp);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic eoi(input string req, input bit exp_b, input logic [7:0] exp_v);
    @(negedge clk);
    eoi_wr = 1'b1;
    @(negedge clk);
    eoi_wr = 1'b0;
    check({req, " bcast valid"}, eoi_bcast_valid, exp_b);
    if (exp_b) check({req, " bcast vector"}, eoi_bcast_vector, exp_v);
    @(negedge clk);
    check({req, " bcast one cycle"}, eoi_bcast_valid, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 irq", irq_out, 0);
    check("R1 bcast", eoi_bcast_valid, 0);
    eoi("R1 empty in-service", 0, 0);
  endtask

  task automatic t_edge_level;
    send(8'h41, 1'b0);
    take("R2 edge", 8'h41);
    check("R4 irq after ack", irq_out, 0);
    eoi("R5 edge no bcast", 0, 0);
    send(8'h52, 1'b1);
    take("R2 level", 8'h52);
    eoi("R5 level bcast", 1, 8'h52);
  endtask

  task automatic t_priority;
    send(8'h30, 1'b0);
    send(8'h71, 1'b0);
    send(8'h35, 1'b0);
    take("R3 highest", 8'h71);
    check("R3 lower class masked", irq_out, 0);
    send(8'h90, 1'b1);
    take("R3 nested", 8'h90);
    eoi("R5 retires highest", 1, 8'h90);
    check("R3 still masked by 0x71", irq_out, 0);
    eoi("R5 edge 0x71", 0, 0);
    take("R3 next pending", 8'h35);
    check("R3 same class blocked", irq_out, 0);
    eoi("R5 0x35", 0, 0);
    take("R3 last pending", 8'h30);
    eoi("R5 0x30", 0, 0);
  endtask

  task automatic t_tpr;
    @(negedge clk); tpr_wr = 1'b1; tpr_data = 8'h60;
    @(negedge clk); tpr_wr = 1'b0;
    send(8'h55, 1'b0);
    check("R10 below tpr masked", irq_out, 0);
    send(8'h65, 1'b0);
    check("R10 equal class masked", irq_out, 0);
    send(8'h75, 1'b0);
    take("R10 above tpr", 8'h75);
    eoi("R10 eoi", 0, 0);
    check("R10 still masked", irq_out, 0);
    @(negedge clk); tpr_wr = 1'b1; tpr_data = 8'h00;
    @(negedge clk); tpr_wr = 1'b0;
    take("R10 tpr zero", 8'h65);
    eoi("R10 eoi 65", 0, 0);
    take("R10 tpr zero 55", 8'h55);
    eoi("R10 eoi 55", 0, 0);
  endtask

  task automatic t_repeat;
    send(8'h48, 1'b0);
    take("R7 first", 8'h48);
    send(8'h48, 1'b0);
    send(8'h48, 1'b0);
    send(8'h48, 1'b0);
    check("R7 repeat held", irq_out, 0);
    eoi("R7 eoi first", 0, 0);
    take("R7 second", 8'h48);
    eoi("R7 eoi second", 0, 0);
    @(negedge clk);
    check("R8 third lost", irq_out, 0);
  endtask

  task automatic t_absorb;
    send(8'h66, 1'b1);
    send(8'h66, 1'b0);
    send(8'h66, 1'b0);
    take("R8 one delivery", 8'h66);
    eoi("R8 kind kept level", 1, 8'h66);
    @(negedge clk);
    check("R8 no extra delivery", irq_out, 0);
  endtask

  task automatic t_empty_eoi;
    eoi("R6 empty", 0, 0);
    send(8'h20, 1'b1);
    take("R6 state intact", 8'h20);
    eoi("R6 then level", 1, 8'h20);
  endtask

  task automatic t_disable;
    @(negedge clk); sw_enable = 1'b0;
    send(8'h80, 1'b0);
    check("R9 irq low", irq_out, 0);
    @(negedge clk); sw_enable = 1'b1;
    @(negedge clk);
    check("R9 message dropped", irq_out, 0);
    send(8'h81, 1'b0);
    @(negedge clk); sw_enable = 1'b0;
    @(negedge clk);
    check("R9 gated", irq_out, 0);
    sw_enable = 1'b1;
    take("R9 kept pending", 8'h81);
    eoi("R9 eoi", 0, 0);
  endtask

  task automatic t_spurious_ack;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check("R4 spurious ack", irq_out, 0);
    send(8'h23, 1'b1);
    take("R4 after spurious ack", 8'h23);
    eoi("R4 eoi", 1, 8'h23);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_edge_level();
    t_priority();
    t_tpr();
    t_repeat();
    t_absorb();
    t_empty_eoi();
    t_disable();
    t_spurious_ack();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule